// File: doc/BRIEF.md
# Triple Match-Compare Timer

A register-mapped block that holds three independent counters. Each counter has a reload value and two compare values, and it counts up or down. Software can write a counter's value at any time. Each counter advances on every bus clock cycle, or only on a one-cycle pulse of its own external tick-enable input, and it can be stopped. When the counter runs past the end of its range, it takes its reload value on the same tick and flags an overflow. When the value it takes equals either compare value, it flags a match.

The nine event flags, three for each counter, sit in one shared status register. A shared mask register and a per-counter interrupt enable decide which flags reach the single interrupt line. Software builds a periodic tick by writing the same value into the counter and its reload register. Software arms a one-shot event by writing a future count into a compare register. One counter runs freely from reset, so it can serve as a timestamp source.

Top module: `trio_timer`

## Requirements
- R1: After reset, the control register (offset 0x30) reads 0xA40, with counter 3 enabled and counters 1 and 3 set to count upward. Status (0x34), mask (0x38) and every count, reload and compare register read 0. Counter n has its count at 0x10*(n-1), its reload at +0x4, compare 1 at +0x8 and compare 2 at +0xC.
- R2: Control bit 9+(n-1) set to 1 makes counter n count upward by one per tick. From 0xFFFFFFFF, the counter takes its reload value instead.
- R3: With that direction bit set to 0, counter n counts down by one per tick. From 0, it takes its reload value instead. Either wrap sets status bit 3*(n-1)+2, the overflow flag.
- R4: When count and reload both hold 0xFFFFFFFF-(P-1) on an up counter, an overflow occurs every P ticks.
- R5: A tick that gives the counter a value equal to compare 1 sets status bit 3*(n-1). A tick that gives a value equal to compare 2 sets status bit 3*(n-1)+1.
- R6: A write to the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. An event in the same cycle wins over the clear.
- R7: irq is 1 exactly when some status bit is 1, its mask bit is 0, and control bit 3*(n-1)+2 (the interrupt enable of its counter) is 1.
- R8: With control bit 3*(n-1)+1 set to 1, counter n advances only in cycles where tick_ext[n-1] is 1. With it set to 0, counter n advances every cycle.
- R9: With control bit 3*(n-1) (enable) set to 0, counter n holds its value.
- R10: A write to a count register loads the written value in place of that cycle's tick and sets no match or overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick_ext | input | 3 | Per-counter external tick-enable pulses |
| irq | output | 1 | Combined interrupt request |

## Verification
A behavioural model of the counters runs next to the design, and the interrupt line is compared with it on every clock. Counting is tried in both directions, on free-running and pulse-gated ticks, and from a value near each wrap point. These cases separate an off-by-one reload from a correct wrap, and a match taken on the old value from one taken on the new value. The status register is written with all ones, with a single zero and with all zeros, which shows that clears act per bit. Mask and enable are toggled against flags that are already set, to tell the gating of the two apart. A count write that equals a compare value confirms that a software load raises no event.

// File: rtl/trio_timer_pkg.sv
package trio_timer_pkg;
   // Event kinds per counter, also the bit order inside each 3-bit status group
   localparam int EV_CMP1 = 0;
   localparam int EV_CMP2 = 1;
   localparam int EV_WRAP = 2;
   localparam int EV_PER_UNIT = 3;

   // Control fields inside each counter's 3-bit control group
   localparam int CF_RUN = 0;
   localparam int CF_SEL = 1;
   localparam int CF_IEN = 2;

   // Register slots inside a counter's 16-byte window
   typedef enum logic [1:0] {
      SLOT_COUNT  = 2'd0,
      SLOT_RELOAD = 2'd1,
      SLOT_CMP1   = 2'd2,
      SLOT_CMP2   = 2'd3
   } unit_slot_e;
endpackage

// File: rtl/trio_timer_cmp.sv
module trio_timer_cmp #(
   parameter int CNT_W = 32
) (
   input  logic             advance,
   input  logic [CNT_W-1:0] next_val,
   input  logic [CNT_W-1:0] ref_val,
   output logic             hit
);
   always_comb hit = advance && (next_val == ref_val);
endmodule

// File: rtl/trio_timer_unit.sv
module trio_timer_unit
   import trio_timer_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int NUM_CMP = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          run_en,
   input  logic                          clk_sel,
   input  logic                          ext_tick,
   input  logic                          count_up,
   input  logic                          cnt_we,
   input  logic [CNT_W-1:0]              cnt_wdata,
   input  logic [CNT_W-1:0]              reload_val,
   input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_vals,
   output logic [CNT_W-1:0]              cnt_q,
   output logic [EV_PER_UNIT-1:0]        evt_hit
);
   localparam logic [CNT_W-1:0] TOP_VAL = '1;
   localparam logic [CNT_W-1:0] BOT_VAL = '0;

   if (NUM_CMP != EV_PER_UNIT - 1) begin : g_bad_cmp
      initial $fatal(1, "trio_timer_unit: NUM_CMP must be %0d", EV_PER_UNIT - 1);
   end

   logic             step;
   logic             advance;
   logic             at_edge;
   logic [CNT_W-1:0] cnt_nx;
   logic [NUM_CMP-1:0] cmp_hit;

   always_comb begin
      step    = run_en && (clk_sel ? ext_tick : 1'b1);
      advance = step && !cnt_we;
      at_edge = count_up ? (cnt_q == TOP_VAL) : (cnt_q == BOT_VAL);
      if (at_edge)       cnt_nx = reload_val;
      else if (count_up) cnt_nx = cnt_q + 1'b1;
      else               cnt_nx = cnt_q - 1'b1;
   end

   for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
      trio_timer_cmp #(.CNT_W(CNT_W)) u_cmp (
         .advance  (advance),
         .next_val (cnt_nx),
         .ref_val  (cmp_vals[c]),
         .hit      (cmp_hit[c])
      );
   end

   always_comb begin
      evt_hit          = '0;
      evt_hit[EV_CMP1] = cmp_hit[0];
      evt_hit[EV_CMP2] = cmp_hit[1];
      evt_hit[EV_WRAP] = advance && at_edge;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (cnt_we)  cnt_q <= cnt_wdata;
      else if (advance) cnt_q <= cnt_nx;
   end

   // R9: a stopped counter keeps its value
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !cnt_we) |=> $stable(cnt_q));
   // R2: one step upward below the top value
   p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_we && count_up && cnt_q != TOP_VAL) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R3: a wrap lands on the reload value
   p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_hit[EV_WRAP] |=> (cnt_q == $past(reload_val)));
   // R10: a software load wins over the tick
   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt_q == $past(cnt_wdata)));
endmodule

// File: rtl/trio_timer_flags.sv
module trio_timer_flags #(
   parameter int NBITS = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] evt_set,
   input  logic             clr_we,
   input  logic [NBITS-1:0] clr_data,
   input  logic             mask_we,
   input  logic [NBITS-1:0] mask_data,
   input  logic [NBITS-1:0] gate_en,
   output logic [NBITS-1:0] status_q,
   output logic [NBITS-1:0] mask_q,
   output logic             irq
);
   logic [NBITS-1:0] status_d;

   always_comb begin
      status_d = clr_we ? (status_q & clr_data) : status_q;
      status_d = status_d | evt_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
      end else begin
         status_q <= status_d;
         if (mask_we) mask_q <= mask_data;
      end
   end

   always_comb irq = |(status_q & ~mask_q & gate_en);

   // R6: without a status write no flag drops
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));
   // R5: every event leaves its flag set
   p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));
   // R7: a fully masked block never interrupts
   p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq);
endmodule

// File: rtl/trio_timer.sv
module trio_timer
   import trio_timer_pkg::*;
#(
   parameter int              NUM_TMR    = 3,
   parameter int              CNT_W      = 32,
   parameter int              DATA_W     = 32,
   parameter int              ADDR_W     = 8,
   parameter logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0A40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_TMR-1:0]  tick_ext,
   output logic                irq
);
   localparam int ST_W      = EV_PER_UNIT * NUM_TMR;
   localparam int DIR_BASE  = ST_W;
   localparam int CTRL_W    = ST_W + NUM_TMR;
   localparam int NUM_CMP   = 2;
   localparam int WIN_BYTES = 16;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_TMR * WIN_BYTES);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_TMR * WIN_BYTES + 4);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NUM_TMR * WIN_BYTES + 8);

   if (CNT_W > DATA_W || CTRL_W > DATA_W) begin : g_bad_width
      initial $fatal(1, "trio_timer: data bus narrower than a register");
   end
   if ((NUM_TMR * WIN_BYTES + 12) > (1 << ADDR_W)) begin : g_bad_addr
      initial $fatal(1, "trio_timer: address width too small for the map");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [NUM_TMR-1:0][CNT_W-1:0] reload_q;
   logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0] cmp_q;
   logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q;
   logic [NUM_TMR-1:0] cnt_we;
   logic [ST_W-1:0] evt_all;
   logic [ST_W-1:0] gate_en;
   logic [ST_W-1:0] status_q;
   logic [ST_W-1:0] mask_q;
   logic stat_we;
   logic mask_we;

   always_comb begin
      stat_we = reg_we && (reg_addr == A_STAT);
      mask_we = reg_we && (reg_addr == A_MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= CTRL_RESET[CTRL_W-1:0];
      else if (reg_we && reg_addr == A_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
   end

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_unit
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(t * WIN_BYTES);
      logic [EV_PER_UNIT-1:0] hit;

      always_comb cnt_we[t] = reg_we && (reg_addr == BASE + ADDR_W'(int'(SLOT_COUNT) * 4));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            reload_q[t] <= '0;
            cmp_q[t]    <= '0;
         end else if (reg_we) begin
            if (reg_addr == BASE + ADDR_W'(int'(SLOT_RELOAD) * 4))
               reload_q[t] <= reg_wdata[CNT_W-1:0];
            if (reg_addr == BASE + ADDR_W'(int'(SLOT_CMP1) * 4))
               cmp_q[t][0] <= reg_wdata[CNT_W-1:0];
            if (reg_addr == BASE + ADDR_W'(int'(SLOT_CMP2) * 4))
               cmp_q[t][1] <= reg_wdata[CNT_W-1:0];
         end
      end

      trio_timer_unit #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_unit (
         .clk        (clk),
         .rst_n      (rst_n),
         .run_en     (ctrl_q[EV_PER_UNIT*t + CF_RUN]),
         .clk_sel    (ctrl_q[EV_PER_UNIT*t + CF_SEL]),
         .ext_tick   (tick_ext[t]),
         .count_up   (ctrl_q[DIR_BASE + t]),
         .cnt_we     (cnt_we[t]),
         .cnt_wdata  (reg_wdata[CNT_W-1:0]),
         .reload_val (reload_q[t]),
         .cmp_vals   (cmp_q[t]),
         .cnt_q      (cnt_q[t]),
         .evt_hit    (hit)
      );

      always_comb begin
         evt_all[EV_PER_UNIT*t +: EV_PER_UNIT] = hit;
         gate_en[EV_PER_UNIT*t +: EV_PER_UNIT] = {EV_PER_UNIT{ctrl_q[EV_PER_UNIT*t + CF_IEN]}};
      end
   end

   trio_timer_flags #(.NBITS(ST_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_set   (evt_all),
      .clr_we    (stat_we),
      .clr_data  (reg_wdata[ST_W-1:0]),
      .mask_we   (mask_we),
      .mask_data (reg_wdata[ST_W-1:0]),
      .gate_en   (gate_en),
      .status_q  (status_q),
      .mask_q    (mask_q),
      .irq       (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CTRL) reg_rdata = DATA_W'(ctrl_q);
      if (reg_addr == A_STAT) reg_rdata = DATA_W'(status_q);
      if (reg_addr == A_MASK) reg_rdata = DATA_W'(mask_q);
      for (int t = 0; t < NUM_TMR; t++) begin
         if (reg_addr == ADDR_W'(t * WIN_BYTES + 0))  reg_rdata = DATA_W'(cnt_q[t]);
         if (reg_addr == ADDR_W'(t * WIN_BYTES + 4))  reg_rdata = DATA_W'(reload_q[t]);
         if (reg_addr == ADDR_W'(t * WIN_BYTES + 8))  reg_rdata = DATA_W'(cmp_q[t][0]);
         if (reg_addr == ADDR_W'(t * WIN_BYTES + 12)) reg_rdata = DATA_W'(cmp_q[t][1]);
      end
   end

   // R1: the control register comes out of reset with its default pattern
   p_ctrl_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (ctrl_q == CTRL_RESET[CTRL_W-1:0]));
endmodule

// File: tb/trio_timer_tb.sv
module trio_timer_tb;
   localparam time CLK_P = 8ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  tick_ext = '0;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit live = 1'b0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   trio_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_ext(tick_ext), .irq(irq)
   );

   // behavioural reference model
   logic [31:0] m_cnt [3];
   logic [31:0] m_ld  [3];
   logic [31:0] m_c1  [3];
   logic [31:0] m_c2  [3];
   logic [11:0] m_ctrl;
   logic [8:0]  m_st, m_mk;

   always @(posedge clk) begin
      logic [8:0] ev;
      if (!rst_n) begin
         for (int t = 0; t < 3; t++) begin
            m_cnt[t] = 0; m_ld[t] = 0; m_c1[t] = 0; m_c2[t] = 0;
         end
         m_ctrl = 12'hA40; m_st = 0; m_mk = 0;
      end else begin
         ev = 0;
         for (int t = 0; t < 3; t++) begin
            bit go;
            go = m_ctrl[3*t] && (m_ctrl[3*t+1] ? tick_ext[t] : 1'b1);
            if (reg_we && reg_addr == 8'(16*t)) m_cnt[t] = reg_wdata;
            else if (go) begin
               if (m_ctrl[9+t]) begin
                  if (m_cnt[t] == 32'hFFFF_FFFF) begin m_cnt[t] = m_ld[t]; ev[3*t+2] = 1; end
                  else m_cnt[t] = m_cnt[t] + 1;
               end else begin
                  if (m_cnt[t] == 0) begin m_cnt[t] = m_ld[t]; ev[3*t+2] = 1; end
                  else m_cnt[t] = m_cnt[t] - 1;
               end
               if (m_cnt[t] == m_c1[t]) ev[3*t] = 1;
               if (m_cnt[t] == m_c2[t]) ev[3*t+1] = 1;
            end
         end
         if (reg_we) begin
            for (int t = 0; t < 3; t++) begin
               if (reg_addr == 8'(16*t+4))  m_ld[t] = reg_wdata;
               if (reg_addr == 8'(16*t+8))  m_c1[t] = reg_wdata;
               if (reg_addr == 8'(16*t+12)) m_c2[t] = reg_wdata;
            end
            if (reg_addr == 8'h30) m_ctrl = reg_wdata[11:0];
            if (reg_addr == 8'h38) m_mk = reg_wdata[8:0];
            if (reg_addr == 8'h34) m_st = m_st & reg_wdata[8:0];
         end
         m_st = m_st | ev;
      end
   end

   function automatic logic m_irq();
      logic [8:0] g;
      for (int t = 0; t < 3; t++) g[3*t +: 3] = {3{m_ctrl[3*t+2]}};
      return |(m_st & ~m_mk & g);
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      logic [31:0] v;
      v = 0;
      if (a == 8'h30) v = 32'(m_ctrl);
      if (a == 8'h34) v = 32'(m_st);
      if (a == 8'h38) v = 32'(m_mk);
      for (int t = 0; t < 3; t++) begin
         if (a == 8'(16*t))    v = m_cnt[t];
         if (a == 8'(16*t+4))  v = m_ld[t];
         if (a == 8'(16*t+8))  v = m_c1[t];
         if (a == 8'(16*t+12)) v = m_c2[t];
      end
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   // interrupt compared with the model on every clock
   always @(negedge clk) begin
      if (live) check("R7 irq per cycle", 32'(irq), 32'(m_irq()));
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string req, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1;
      v = reg_rdata;
      check(req, v, m_read(a));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ext(input int idx);
      @(negedge clk);
      tick_ext[idx] = 1'b1;
      @(negedge clk);
      tick_ext[idx] = 1'b0;
      idle(2);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

   initial begin
      logic [31:0] v, c0;
      idle(4);
      @(negedge clk); rst_n = 1'b1;
      live = 1'b1;

      // R1 reset state
      rd(8'h30, "R1 ctrl", v);   check("R1 ctrl literal", v, 32'h0000_0A40);
      rd(8'h34, "R1 status", v); check("R1 status literal", v, 0);
      rd(8'h38, "R1 mask", v);   check("R1 mask literal", v, 0);
      rd(8'h04, "R1 reload1", v);
      rd(8'h28, "R1 cmp1 of counter 3", v);
      rd(8'h20, "R1 free counter 3", v);

      // R9 disabled counter holds
      idle(20);
      rd(8'h00, "R9 hold", v); check("R9 hold literal", v, 0);

      // R2 up counting
      wr(8'h00, 32'd100);
      wr(8'h30, 32'hA41);
      idle(7);
      rd(8'h00, "R2 up count", v);
      check("R2 advanced", 32'(v > 32'd100), 1);
      rd(8'h20, "R2 counter 3 free run", v);

      // R5 compare events
      wr(8'h08, m_cnt[0] + 32'd30);
      wr(8'h0C, m_cnt[0] + 32'd40);
      idle(50);
      rd(8'h34, "R5 status", v); check("R5 both compare flags", v & 32'h3, 32'h3);

      // R7 gating by enable and mask
      check("R7 ie off", 32'(irq), 0);
      wr(8'h30, 32'hA45);
      check("R7 ie on", 32'(irq), 1);
      wr(8'h38, 32'h003);
      check("R7 masked", 32'(irq), 0);
      wr(8'h38, 32'h000);

      // R6 per-bit clear
      wr(8'h34, 32'h1FE);
      rd(8'h34, "R6 clear one", v); check("R6 clear one literal", v & 32'h3, 32'h2);
      wr(8'h34, 32'h1FF);
      rd(8'h34, "R6 write ones", v); check("R6 ones keep", v & 32'h3, 32'h2);
      wr(8'h34, 32'h000);
      rd(8'h34, "R6 clear all", v);

      // R3 down counting and wrap
      wr(8'h10, 32'd5);
      wr(8'h14, 32'd200);
      wr(8'h30, 32'hA4D);
      idle(10);
      rd(8'h34, "R3 status", v); check("R3 wrap flag", (v >> 5) & 1, 1);
      rd(8'h10, "R3 down count", v);
      check("R3 below reload", 32'(v < 32'd200), 1);

      // R4 periodic overflow, period 10
      wr(8'h30, 32'hA48);
      wr(8'h00, 32'hFFFF_FFF6);
      wr(8'h04, 32'hFFFF_FFF6);
      wr(8'h38, 32'h1FB);
      wr(8'h34, 32'h000);
      wr(8'h30, 32'hA4D);
      for (int k = 0; k < 35; k++) rd(8'h00, "R4 periodic count", v);
      rd(8'h34, "R4 status", v); check("R4 overflow flag", (v >> 2) & 1, 1);
      wr(8'h34, 32'h000);
      idle(23);
      rd(8'h34, "R4 status again", v);

      // R8 external tick select on counter 2
      wr(8'h38, 32'h000);
      wr(8'h30, 32'hA5D);
      rd(8'h10, "R8 base", c0);
      idle(6);
      rd(8'h10, "R8 frozen", v); check("R8 frozen literal", v, c0);
      pulse_ext(1); pulse_ext(1); pulse_ext(1);
      rd(8'h10, "R8 three ticks", v); check("R8 minus three", v, c0 - 32'd3);

      // R10 software load, no event
      wr(8'h18, 32'h777);
      wr(8'h34, 32'h000);
      wr(8'h10, 32'h777);
      rd(8'h10, "R10 loaded", v); check("R10 load literal", v, 32'h777);
      rd(8'h34, "R10 no flag", v); check("R10 no compare flag", (v >> 3) & 1, 0);

      // R9 stop counter 1
      wr(8'h30, 32'hA5C);
      rd(8'h00, "R9 stopped", c0);
      idle(15);
      rd(8'h00, "R9 still", v); check("R9 still literal", v, c0);

      idle(3);
      finish_up();
   end
endmodule